// File: doc/BRIEF.md
# Timer Output Flip-Flop Controller

This block drives one timer output pin from a single flip-flop. An external counter and its compare logic report two compare-match strobes (A and B) and an overflow strobe. All three are qualified by a count-clock enable. An 8-bit control register sets how those events change the flip-flop. Software can force the flip-flop high or low. A pin enable holds the pin low whenever it is cleared.

There are two output modes. In continuous mode, each compare match whose toggle enable is set inverts the flip-flop. In one-shot mode, a self-clearing software trigger arms the block. The next compare-B match drives the output high, and the following compare-A match, or an overflow, drives it low. The block then ignores further matches until the next trigger. While the timer runs, the configuration is frozen: only the trigger bit takes effect. Back-to-back triggers must be spaced by a minimum number of count-clock ticks.

Top module: `tmr_out_ff_ctrl`

## Requirements
- R1: After reset, the pin is 0 and the register reads 0x00. The register layout is: bit 0 pin enable, bit 1 compare-A toggle enable, bits 3:2 software command, bit 4 compare-B toggle enable, bit 5 one-shot mode, bit 6 trigger, bit 7 reserved. Bits 7, 6, 3 and 2 always read 0.
- R2: A write to command bits 3:2 acts on the flip-flop at that clock edge: 01 clears it, 10 sets it, and 00 or 11 leave it unchanged.
- R3: In continuous mode, a compare-A strobe with bit 1 set inverts the flip-flop, and so does a compare-B strobe with bit 4 set. A strobe counts only when the count-clock enable is high. Two enabled strobes in the same cycle cancel each other.
- R4: With bit 0 clear, the pin is 0 whatever the flip-flop holds. With bit 0 set, the pin follows the flip-flop.
- R5: In one-shot mode (bit 5 = 1), an accepted trigger arms the block. The next compare-B match sets the flip-flop, and the next compare-A match after that clears it and disarms the block. Matches that arrive out of this order, or while the block is disarmed, have no effect, and the toggle enables are not used.
- R6: In one-shot mode, an overflow ends a pulse that is high (clears the flip-flop and disarms the block). An overflow while the block waits for compare B has no effect.
- R7: Writing 1 to bit 6 requests a trigger. The bit is never stored. The request is ignored unless the one-shot mode bit is already 1.
- R8: While the timer-running input is high, a write changes no field other than the trigger request.
- R9: A trigger is accepted only if at least 2 count-clock enables have occurred since the last accepted trigger. Reset counts as "long ago", so the first trigger after reset is accepted. A rejected trigger changes nothing.
- R10: A software set or clear command takes priority over a compare-match or one-shot event in the same cycle.
- R11: An accepted trigger while a pulse is high restarts the wait for compare B and leaves the pin level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read-back (masked) |
| cnt_en_i | input | 1 | Count-clock enable qualifying the strobes |
| match_a_i | input | 1 | Compare-A match strobe |
| match_b_i | input | 1 | Compare-B match strobe |
| ovf_i | input | 1 | Counter overflow strobe |
| run_i | input | 1 | Timer running flag |
| pin_o | output | 1 | Timer output pin |

## Verification
The two functions that can fall in the same cycle are a software set/clear command and a compare-match toggle. The bench provokes this with a set command while the flip-flop is already high and a compare-B toggle is enabled and strobed. A toggle would drive the pin low, so a pin that stays high shows that the command won. A second collision, a trigger arriving while a pulse is high, is judged by whether a following compare-A match is ignored.

// File: rtl/tof_pkg.sv
package tof_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_OE    = 0;
  localparam int unsigned B_TGA   = 1;
  localparam int unsigned B_CMD_L = 2;
  localparam int unsigned B_CMD_H = 3;
  localparam int unsigned B_TGB   = 4;
  localparam int unsigned B_OSM   = 5;
  localparam int unsigned B_TRG   = 6;

  typedef enum logic [1:0] {
    CMD_KEEP = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_SET  = 2'b10,
    CMD_BAD  = 2'b11
  } ff_cmd_e;

  typedef enum logic [1:0] {
    OS_IDLE   = 2'd0,
    OS_WAIT_B = 2'd1,
    OS_WAIT_A = 2'd2
  } os_state_e;

  typedef struct packed {
    logic os_mode;
    logic tog_b_en;
    logic tog_a_en;
    logic out_en;
  } cfg_t;
endpackage

// File: rtl/tof_cfg_regs.sv
module tof_cfg_regs
  import tof_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             run_i,
  output cfg_t             cfg_o,
  output logic             cmd_set_o,
  output logic             cmd_clr_o,
  output logic             trig_req_o,
  output logic [REG_W-1:0] rdata_o
);
  cfg_t    cfg_q;
  logic    wr_ok;
  ff_cmd_e cmd;
  logic    unused_rsvd;

  assign wr_ok       = we_i & ~run_i;
  assign cmd         = ff_cmd_e'(wdata_i[B_CMD_H:B_CMD_L]);
  assign unused_rsvd = wdata_i[REG_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      cfg_q.out_en   <= wdata_i[B_OE];
      cfg_q.tog_a_en <= wdata_i[B_TGA];
      cfg_q.tog_b_en <= wdata_i[B_TGB];
      cfg_q.os_mode  <= wdata_i[B_OSM];
    end
  end

  // CMD_BAD is treated as keep
  always_comb begin
    cmd_set_o = 1'b0;
    cmd_clr_o = 1'b0;
    if (wr_ok) begin
      unique case (cmd)
        CMD_SET: cmd_set_o = 1'b1;
        CMD_CLR: cmd_clr_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign trig_req_o = we_i & wdata_i[B_TRG];

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_OE]   = cfg_q.out_en;
    rdata_o[B_TGA]  = cfg_q.tog_a_en;
    rdata_o[B_TGB]  = cfg_q.tog_b_en;
    rdata_o[B_OSM]  = cfg_q.os_mode;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tof_trig_gate.sv
module tof_trig_gate #(
  parameter int unsigned MIN_GAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_en_i,
  input  logic os_mode_i,
  input  logic trig_req_i,
  output logic trig_ok_o
);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] gap_q;
  logic             gap_met;

  assign gap_met   = (gap_q >= GAP_MAX);
  assign trig_ok_o = trig_req_i & os_mode_i & gap_met;

  // saturating tick counter since last accepted trigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_MAX;
    end else if (trig_ok_o) begin
      gap_q <= '0;
    end else if (cnt_en_i && !gap_met) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/tof_oneshot_seq.sv
module tof_oneshot_seq
  import tof_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic os_mode_i,
  input  logic cnt_en_i,
  input  logic match_a_i,
  input  logic match_b_i,
  input  logic ovf_i,
  input  logic trig_ok_i,
  output logic seq_set_o,
  output logic seq_clr_o
);
  os_state_e state_q, state_d;
  logic      ev_ok;

  assign ev_ok     = os_mode_i & cnt_en_i & ~trig_ok_i;
  assign seq_set_o = ev_ok & (state_q == OS_WAIT_B) & match_b_i;
  assign seq_clr_o = ev_ok & (state_q == OS_WAIT_A) & (match_a_i | ovf_i);

  always_comb begin
    state_d = state_q;
    if (!os_mode_i)     state_d = OS_IDLE;
    else if (trig_ok_i) state_d = OS_WAIT_B;
    else if (seq_set_o) state_d = OS_WAIT_A;
    else if (seq_clr_o) state_d = OS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/tof_ff_core.sv
module tof_ff_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_en_i,
  input  logic os_mode_i,
  input  logic tog_a_en_i,
  input  logic tog_b_en_i,
  input  logic cnt_en_i,
  input  logic match_a_i,
  input  logic match_b_i,
  input  logic cmd_set_i,
  input  logic cmd_clr_i,
  input  logic seq_set_i,
  input  logic seq_clr_i,
  output logic pin_o
);
  logic ff_q, ff_d, tog;

  assign tog = cnt_en_i & ((tog_a_en_i & match_a_i) ^ (tog_b_en_i & match_b_i));

  // software command has priority over hardware events
  always_comb begin
    ff_d = ff_q;
    if (cmd_set_i)      ff_d = 1'b1;
    else if (cmd_clr_i) ff_d = 1'b0;
    else if (os_mode_i) begin
      if (seq_set_i)      ff_d = 1'b1;
      else if (seq_clr_i) ff_d = 1'b0;
    end else begin
      ff_d = ff_q ^ tog;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 1'b0;
    else         ff_q <= ff_d;
  end

  assign pin_o = out_en_i & ff_q;
endmodule

// File: rtl/tmr_out_ff_ctrl.sv
module tmr_out_ff_ctrl
  import tof_pkg::*;
#(
  parameter int unsigned MIN_GAP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             cnt_en_i,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             ovf_i,
  input  logic             run_i,
  output logic             pin_o
);
  cfg_t cfg;
  logic cmd_set, cmd_clr, trig_req, trig_ok, seq_set, seq_clr;

  tof_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .run_i      (run_i),
    .cfg_o      (cfg),
    .cmd_set_o  (cmd_set),
    .cmd_clr_o  (cmd_clr),
    .trig_req_o (trig_req),
    .rdata_o    (cfg_rdata_o)
  );

  tof_trig_gate #(.MIN_GAP(MIN_GAP)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en_i),
    .os_mode_i  (cfg.os_mode),
    .trig_req_i (trig_req),
    .trig_ok_o  (trig_ok)
  );

  tof_oneshot_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .os_mode_i (cfg.os_mode),
    .cnt_en_i  (cnt_en_i),
    .match_a_i (match_a_i),
    .match_b_i (match_b_i),
    .ovf_i     (ovf_i),
    .trig_ok_i (trig_ok),
    .seq_set_o (seq_set),
    .seq_clr_o (seq_clr)
  );

  tof_ff_core u_ff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .out_en_i   (cfg.out_en),
    .os_mode_i  (cfg.os_mode),
    .tog_a_en_i (cfg.tog_a_en),
    .tog_b_en_i (cfg.tog_b_en),
    .cnt_en_i   (cnt_en_i),
    .match_a_i  (match_a_i),
    .match_b_i  (match_b_i),
    .cmd_set_i  (cmd_set),
    .cmd_clr_i  (cmd_clr),
    .seq_set_i  (seq_set),
    .seq_clr_i  (seq_clr),
    .pin_o      (pin_o)
  );
endmodule

// File: rtl/tof_checker.sv
module tof_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       cnt_en_i,
  input logic       run_i,
  input logic       pin_o
);
  a_r1_masked_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & 8'hCC) == 8'h00);

  a_r4_pin_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[0] |-> !pin_o);

  a_r8_run_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && run_i) |=> $stable(cfg_rdata_o));

  a_r2_set_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !run_i && cfg_wdata_i[3:2] == 2'b10 && cfg_wdata_i[0]) |=> pin_o);

  a_r2_clr_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !run_i && cfg_wdata_i[3:2] == 2'b01) |=> !pin_o);

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !cnt_en_i) |=> $stable(pin_o));
endmodule

bind tmr_out_ff_ctrl tof_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .cnt_en_i    (cnt_en_i),
  .run_i       (run_i),
  .pin_o       (pin_o)
);

// File: tb/tmr_out_ff_ctrl_test.sv
`timescale 1ns/1ps
module tmr_out_ff_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       ce = 1'b0, ma = 1'b0, mb = 1'b0, ovf = 1'b0, run = 1'b0;
  logic       pin;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  tmr_out_ff_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .cfg_rdata_o(rd), .cnt_en_i(ce), .match_a_i(ma), .match_b_i(mb),
    .ovf_i(ovf), .run_i(run), .pin_o(pin)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic       run;
    logic       ce;
    logic       ma;
    logic       mb;
    logic       ovf;
    logic       pin;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 41;
  // bits: 01 OE, 02 TGA, 04 CLR, 08 SET, 10 TGB, 20 ONESHOT, 40 TRIG
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1,8'h09,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h01,4'd2},  // R2 set
    '{1'b1,8'h05,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h01,4'd2},  // R2 clear
    '{1'b1,8'h0D,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h01,4'd2},  // R2 11 = keep
    '{1'b1,8'h13,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h13,4'd3},
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,8'h13,4'd3},  // R3 A toggles
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,8'h13,4'd3},  // R3 B toggles
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,8'h13,4'd3},  // R3 both cancel
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,8'h13,4'd3},  // R3 no count enable
    '{1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h11,4'd3},
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,8'h11,4'd3},  // R3 A disabled
    '{1'b1,8'h19,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h11,4'd2},
    '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h10,4'd4},  // R4 gated
    '{1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h11,4'd4},  // R4 follows ff
    '{1'b1,8'h05,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h11,4'd8},  // R8 locked
    '{1'b1,8'h19,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h11,4'd10}, // R10 set beats toggle
    '{1'b1,8'h25,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd5},
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,8'h21,4'd5},  // R5 disarmed
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd7},  // R7 trigger
    '{1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,8'h21,4'd5},  // R5 A before B
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd5},  // R5 B sets
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd5},
    '{1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,8'h21,4'd5},  // R5 A clears
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,8'h21,4'd5},
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd9},
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd5},
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h21,4'd9},  // R9 too soon
    '{1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,8'h21,4'd9},  // R9 rejected
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd9},
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd5},
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,8'h21,4'd9},
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h21,4'd11}, // R11 retrigger
    '{1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,8'h21,4'd11}, // R11 A ignored
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd5},
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,8'h21,4'd6},  // R6 ovf ends
    '{1'b1,8'h01,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h01,4'd7},
    '{1'b1,8'h41,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h01,4'd7},  // R7 mode off
    '{1'b1,8'h21,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd7},
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,8'h21,4'd7},  // R7 not armed
    '{1'b1,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h21,4'd6},
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,8'h21,4'd6},  // R6 ovf waiting B
    '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd6}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] d, input logic r,
                       input logic c, input logic a, input logic b, input logic o);
    @(negedge clk);
    we = w; wd = d; run = r; ce = c; ma = a; mb = b; ovf = o;
    @(posedge clk);
    #2;
    we = 1'b0; ce = 1'b0; ma = 1'b0; mb = 1'b0; ovf = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset pin", {7'd0, pin}, 8'h00);
    check("R1 reset rdata", rd, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].wd, VECS[i].run, VECS[i].ce,
            VECS[i].ma, VECS[i].mb, VECS[i].ovf);
      check($sformatf("R%0d vec%0d pin", VECS[i].req, i), {7'd0, pin}, {7'd0, VECS[i].pin});
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].rd);
    end

    // R1: reset in the middle of a high pulse
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 async reset pin", {7'd0, pin}, 8'h00);
    check("R1 async reset rdata", rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: first trigger after reset is accepted without gap ticks
    drive(1'b1, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R9 first trigger after reset", {7'd0, pin}, 8'h01);

    // R1: all-ones write reads back with masked bits cleared
    drive(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 masked readback", rd, 8'h33);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule